// File: doc/BRIEF.md
# Serial Program Image Loader

This block loads a program image into an instruction memory over a single asynchronous serial input. It decodes each incoming character with an on-board receiver that runs at a fixed bit time, given as a count of system clocks per bit. It then assembles groups of four characters into 32-bit words and presents each finished word on a memory write port. The memory, the processor that later fetches from it, and any return path are outside the block.

The block raises a ready output once it leaves reset, which tells the external sender it may start streaming. The image carries no length field. A reserved sentinel word closes it. That word is never stored; it sets a sticky done flag, and from then on the serial line has no effect until the next reset. A character whose stop bit reads low sets a sticky framing-error flag and is thrown away.

Top module: `uart_prog_loader`

## Requirements
- R1: The serial line idles high. A frame is one low start bit, eight data bits with bit 0 first, and one high stop bit. Each bit lasts CLKS_PER_BIT clock cycles, and data bits are sampled near their centre.
- R2: A low pulse on the idle line that is high again when it is re-checked, half a bit time after detection, is dropped. It produces no byte and does not disturb the byte count.
- R3: Four accepted bytes form one word, with the first byte in bits 31:24 and the last in bits 7:0. Each word other than the sentinel appears on memData while memWe is high.
- R4: memWe is high for exactly one cycle per word. memAddr is 0 after reset, shows the word's address during that pulse, and then increases by one.
- R5: The word 32'h00000FFF is not written. It sets loadDone, which stays high until reset, and memAddr does not advance.
- R6: While loadDone is high, serial traffic causes no write and no change to memAddr.
- R7: A frame whose stop bit samples low sets frameErr, which stays high until reset. That byte is discarded and the bytes already gathered for the current word are kept.
- R8: loadReady is low while rst is high. It goes high at the first clock edge after rst falls and drops when loadDone rises.
- R9: A synchronous reset clears loadDone, frameErr, memAddr and the count of gathered bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxLine | input | 1 | Serial receive line, idle high |
| loadReady | output | 1 | Sender may start transmitting |
| memWe | output | 1 | One-cycle memory write strobe |
| memAddr | output | ADDR_W | Word address of the current write |
| memData | output | 32 | Word being written |
| loadDone | output | 1 | Sentinel word received |
| frameErr | output | 1 | Sticky framing-error flag |

## Verification
A wrong byte count or a slip in the bit counter shows up at the ports within one word. The next memData is rotated or corrupted, or memWe fires after the wrong number of characters. An address register that is off by one is visible on the very next write pulse. A lost done or error flag shows within a few cycles of the frame that should have set it, either as a write after the sentinel or as frameErr still low. A rejected start glitch that wrongly counts as a byte misaligns the following word, and that word's compare catches it.

// File: rtl/loader_pkg.sv
package loader_pkg;
  typedef struct packed {
    logic shiftBit;
    logic byteOk;
    logic frameBad;
  } rxStrobe_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_RECOVER
  } rxState_t;

  localparam logic [31:0] END_WORD = 32'h0000_0FFF;
endpackage

// File: rtl/loader_ctrl.sv
module loader_ctrl
  import loader_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1085
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxBit,
  input  logic       halt,
  output rxStrobe_t  strobe
);
  localparam int CNT_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(CLKS_PER_BIT / 2 - 1);

  rxState_t state;
  logic [CNT_W-1:0] cnt;
  logic [2:0] bitIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RX_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (!halt && !rxBit) state <= RX_START;
        end
        RX_START: begin
          if (cnt == MID) begin
            cnt    <= '0;
            bitIdx <= '0;
            state  <= rxBit ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 1'b1;
        end
        RX_DATA: begin
          if (cnt == LAST) begin
            cnt <= '0;
            if (bitIdx == 3'd7) state <= RX_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        RX_STOP: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= rxBit ? RX_IDLE : RX_RECOVER;
          end else cnt <= cnt + 1'b1;
        end
        RX_RECOVER: if (rxBit) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.shiftBit = (state == RX_DATA) && (cnt == LAST);
    strobe.byteOk   = (state == RX_STOP) && (cnt == LAST) && rxBit;
    strobe.frameBad = (state == RX_STOP) && (cnt == LAST) && !rxBit;
  end

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.shiftBit, strobe.byteOk, strobe.frameBad}));

  // R6
  halt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && state == RX_IDLE) |=> (state == RX_IDLE));
endmodule

// File: rtl/loader_dp.sv
module loader_dp
  import loader_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxBit,
  input  rxStrobe_t         strobe,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic              loadDone,
  output logic              frameErr
);
  logic [7:0]  byteReg;
  logic [23:0] wordReg;
  logic [1:0]  byteCnt;
  logic [31:0] fullWord;

  assign fullWord = {wordReg, byteReg};

  always_ff @(posedge clk) begin
    if (rst) begin
      byteCnt  <= '0;
      memAddr  <= '0;
      memWe    <= 1'b0;
      loadDone <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      memWe <= 1'b0;
      if (memWe) memAddr <= memAddr + ADDR_W'(1);
      if (strobe.shiftBit) byteReg <= {rxBit, byteReg[7:1]};
      if (strobe.frameBad) frameErr <= 1'b1;
      if (strobe.byteOk && !loadDone) begin
        byteCnt <= byteCnt + 1'b1;
        wordReg <= {wordReg[15:0], byteReg};
        if (byteCnt == 2'd3) begin
          if (fullWord == END_WORD) loadDone <= 1'b1;
          else begin
            memWe   <= 1'b1;
            memData <= fullWord;
          end
        end
      end
    end
  end

  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |=> !memWe);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |=> (memAddr == $past(memAddr) + ADDR_W'(1)));

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    loadDone |=> loadDone);

  // R6
  no_write_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    loadDone |-> !memWe);

  // R7
  frame_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    frameErr |=> frameErr);
endmodule

// File: rtl/uart_prog_loader.sv
module uart_prog_loader
  import loader_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1085,
  parameter int ADDR_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxLine,
  output logic              loadReady,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic              loadDone,
  output logic              frameErr
);
  logic [1:0] rxSync;
  logic       readyReg;
  rxStrobe_t  strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxSync   <= 2'b11;
      readyReg <= 1'b0;
    end else begin
      rxSync   <= {rxSync[0], rxLine};
      readyReg <= 1'b1;
    end
  end

  assign loadReady = readyReg && !loadDone;

  loader_ctrl #(.CLKS_PER_BIT(CLKS_PER_BIT)) ctrl_i (
    .clk(clk), .rst(rst), .rxBit(rxSync[1]), .halt(loadDone), .strobe(strobe)
  );

  loader_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rst(rst), .rxBit(rxSync[1]), .strobe(strobe),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .loadDone(loadDone), .frameErr(frameErr)
  );

  // R8
  ready_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(loadDone) |-> !loadReady);
endmodule

// File: tb/uart_prog_loader_tb_top.sv
module uart_prog_loader_tb_top;
  localparam int CPB = 16;
  localparam int AW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxLine = 1'b1;
  logic loadReady, memWe, loadDone, frameErr;
  logic [AW-1:0] memAddr;
  logic [31:0] memData;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [31:0] expQ[$];
  logic [AW-1:0] expAddr = '0;
  logic prevWe = 1'b0;

  always #4 clk = ~clk;

  uart_prog_loader #(.CLKS_PER_BIT(CPB), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .rxLine(rxLine), .loadReady(loadReady),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .loadDone(loadDone), .frameErr(frameErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model: every clock, a write must match the head of the expected queue
  always @(negedge clk) begin
    if (!rst && memWe) begin
      check(!prevWe, "R4", "write strobe longer than one cycle", 32'(prevWe), 32'd0);
      if (expQ.size() == 0)
        check(1'b0, "R6", "write with no word expected", memData, 32'd0);
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check(memData == e, "R1/R3", "write data", memData, e);
        check(memAddr == expAddr, "R4", "write address", 32'(memAddr), 32'(expAddr));
        expAddr = expAddr + 1'b1;
      end
    end
    prevWe = memWe;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic bitWait();
    repeat (CPB) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit stopHigh);
    rxLine = 1'b0;
    bitWait();
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      bitWait();
    end
    rxLine = stopHigh;
    bitWait();
    rxLine = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendWord(input logic [31:0] w);
    sendByte(w[31:24], 1'b1);
    sendByte(w[23:16], 1'b1);
    sendByte(w[15:8], 1'b1);
    sendByte(w[7:0], 1'b1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!loadReady, "R8", "ready during reset", 32'(loadReady), 32'd0);
    check(!memWe && !loadDone && !frameErr, "R9", "flags during reset",
          {29'd0, memWe, loadDone, frameErr}, 32'd0);
    check(memAddr == '0, "R9", "address during reset", 32'(memAddr), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(loadReady, "R8", "ready after reset", 32'(loadReady), 32'd1);

    expQ.push_back(32'hA1B2C3D4);
    sendWord(32'hA1B2C3D4);
    check(expQ.size() == 0, "R3", "first word written", expQ.size(), 0);
    check(memAddr == 8'd1, "R4", "address after first word", 32'(memAddr), 32'd1);

    expQ.push_back(32'h00000FFE);
    sendWord(32'h00000FFE);
    check(!loadDone, "R5", "near-sentinel does not finish", 32'(loadDone), 32'd0);

    // R2: short low glitch
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * CPB) @(negedge clk);
    check(memAddr == 8'd2, "R2", "address after glitch", 32'(memAddr), 32'd2);
    expQ.push_back(32'h5A6B7C8D);
    sendWord(32'h5A6B7C8D);
    check(expQ.size() == 0, "R2", "word after glitch aligned", expQ.size(), 0);

    // R7: bad stop bit in middle of a word
    expQ.push_back(32'h11224455);
    sendByte(8'h11, 1'b1);
    sendByte(8'h22, 1'b1);
    sendByte(8'h33, 1'b0);
    check(frameErr, "R7", "framing error flag", 32'(frameErr), 32'd1);
    sendByte(8'h44, 1'b1);
    sendByte(8'h55, 1'b1);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R7", "partial word kept", expQ.size(), 0);
    check(frameErr, "R7", "framing error sticky", 32'(frameErr), 32'd1);

    // R5: sentinel
    sendWord(32'h00000FFF);
    check(loadDone, "R5", "done after sentinel", 32'(loadDone), 32'd1);
    check(memAddr == 8'd4, "R5", "sentinel not written", 32'(memAddr), 32'd4);
    check(!loadReady, "R8", "ready after done", 32'(loadReady), 32'd0);

    // R6: traffic after done
    sendWord(32'hDEADBEEF);
    check(memAddr == 8'd4, "R6", "address after ignored word", 32'(memAddr), 32'd4);
    check(loadDone, "R6", "done held", 32'(loadDone), 32'd1);

    // R9: second reset
    rst = 1'b1;
    @(negedge clk);
    check(!loadReady, "R8", "ready during second reset", 32'(loadReady), 32'd0);
    rst = 1'b0;
    expAddr = '0;
    @(negedge clk);
    check(!loadDone && !frameErr, "R9", "flags cleared",
          {30'd0, loadDone, frameErr}, 32'd0);
    check(memAddr == '0, "R9", "address cleared", 32'(memAddr), 32'd0);
    check(loadReady, "R8", "ready after second reset", 32'(loadReady), 32'd1);
    expQ.push_back(32'h0BADF00D);
    sendWord(32'h0BADF00D);
    check(expQ.size() == 0 && memAddr == 8'd1, "R9", "reload from address 0",
          32'(memAddr), 32'd1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule